// File: doc/BRIEF.md
# Cascaded Three-Word Event Interrupt Aggregator

This block collects hardware events into three pending words of `WORD_W` bits, giving up to 3 x `WORD_W` event sources. Each event source arrives as a number on a strobed input. Three level interrupt lines leave the block. Each line has its own enable mask for each pending word, and it is high while any enabled pending bit is set.

The top two bits of word 0 are summary bits. Any event that lands in word 1 or word 2 also marks its summary bit in word 0. That summary bit stays set until the word below it drains. Software reads and writes pending and mask words through a small register port. Each pending word has its own clear rule. Word 0 is write-1-to-clear, except that its summary bits are protected. Word 1 cannot be written. Word 2 is write-1-to-clear, and draining it releases its summary bit.

A separate strobed input lets hardware retract one event. If that leaves word 1 or word 2 empty, the matching summary bit is cleared as well. The reset input is asynchronous and is released inside the block through a two-stage synchronizer. After the external release, the block needs two clock edges before it accepts events.

Top module: `evt_irq_agg`

## Requirements
- R1: The event number selects the word with its two top bits and the bit with the rest (bits 6:5 and 4:0 at the default width). A set strobe sets that bit on the next edge. Numbers whose word field is 3 change nothing.
- R2: `irq[0]`, `irq[1]` and `irq[2]` (lines A, B, C) are each high exactly when some pending bit in any of the three words is also set in that line's mask for the same word. They follow register state without an extra cycle.
- R3: A set into word 1 also sets word 0 bit `WORD_W-2` (bit 30). A set into word 2 also sets word 0 bit `WORD_W-1` (bit 31).
- R4: A register write to pending word 0 clears every bit written as 1. The two summary bits (31:30) are not affected.
- R5: A register write to pending word 1 changes nothing.
- R6: A register write to pending word 2 clears every bit written as 1. If word 2 is then zero, word 0 bit 31 is cleared.
- R7: A clear strobe clears the addressed bit on the next edge, in any word. If it leaves word 1 empty, word 0 bit 30 is cleared. If it leaves word 2 empty, word 0 bit 31 is cleared.
- R8: `reg_addr[3:2]` selects the register group: 0 = pending, 1 = mask A, 2 = mask B, 3 = mask C. `reg_addr[1:0]` selects the word. Masks read back what was written. Word index 3 reads zero and ignores writes.
- R9: Reset clears all pending words and all masks, so every interrupt line is low.
- R10: A set and a clear of the same bit in the same cycle leave the bit set. This holds for a hardware clear and for a software clear alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_set_valid | input | 1 | Event set strobe |
| ev_set_id | input | ID_W (7) | Event number to set |
| ev_clr_valid | input | 1 | Hardware clear strobe |
| ev_clr_id | input | ID_W (7) | Event number to clear |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register group and word select |
| reg_wdata | input | WORD_W | Write data |
| reg_rdata | output | WORD_W | Combinational read data |
| irq | output | 3 | Interrupt lines A, B, C |

## Verification
Any wrong pending bit shows up at `reg_rdata` on the clock edge after the stimulus. It also shows at `irq` at once, whenever the bit is enabled by a mask. A lost or stuck summary bit appears only in word 0. For that reason, the checks read word 0 after every cascade event, every drain and every protected-bit write. The same-cycle set and clear cases are driven on purpose, because a priority error there leaves a silently missing bit that no later stimulus repairs.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned N_WORDS = 3;
  localparam int unsigned N_OUT   = 3;

  typedef enum logic [1:0] {
    SEL_PEND  = 2'd0,
    SEL_MSK_A = 2'd1,
    SEL_MSK_B = 2'd2,
    SEL_MSK_C = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/evt_decode.sv
module evt_decode
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned BIT_W = $clog2(WORD_W),
  localparam int unsigned ID_W  = BIT_W + 2
) (
  input  logic                                  vld,
  input  logic [ID_W-1:0]                       id,
  output logic [N_WORDS-1:0][WORD_W-1:0]        hit
);
  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    assign hit[w] = (vld && (id[ID_W-1:BIT_W] == 2'(w)))
                    ? (ONE << id[BIT_W-1:0]) : '0;
  end
endmodule

// File: rtl/evt_pend_core.sv
module evt_pend_core
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [N_WORDS-1:0][WORD_W-1:0] set_hit,
  input  logic [N_WORDS-1:0][WORD_W-1:0] clr_hit,
  input  logic                           sw_wr,
  input  logic [1:0]                     sw_word,
  input  logic [WORD_W-1:0]              sw_wdata,
  output logic [N_WORDS-1:0][WORD_W-1:0] pend
);
  localparam logic [WORD_W-1:0] SUMMARY = {2'b11, {(WORD_W-2){1'b0}}};

  logic [N_WORDS-1:0][WORD_W-1:0] sw_clr, stage, pend_nxt;
  logic                           drain1, drain2, sw_hits_w2, pend_en;
  logic [WORD_W-1:0]              drain_mask, casc_mask;

  always_comb begin
    sw_clr     = '0;
    sw_hits_w2 = sw_wr && (sw_word == 2'd2);
    if (sw_wr && (sw_word == 2'd0)) sw_clr[0] = sw_wdata & ~SUMMARY;
    if (sw_hits_w2)                 sw_clr[2] = sw_wdata;
    for (int w = 0; w < N_WORDS; w++)
      stage[w] = (pend[w] & ~(sw_clr[w] | clr_hit[w])) | set_hit[w];
    drain1     = (|clr_hit[1]) && (stage[1] == '0);
    drain2     = ((|clr_hit[2]) || sw_hits_w2) && (stage[2] == '0);
    drain_mask = {drain2, drain1, {(WORD_W-2){1'b0}}};
    casc_mask  = {|set_hit[2], |set_hit[1], {(WORD_W-2){1'b0}}};
    pend_nxt    = stage;
    pend_nxt[0] = (stage[0] & ~drain_mask) | set_hit[0] | casc_mask;
    pend_en     = (|set_hit) || (|clr_hit) || sw_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= '0;
    else if (pend_en) pend <= pend_nxt;
  end
endmodule

// File: rtl/evt_mask_bank.sv
module evt_mask_bank
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic                                         clk,
  input  logic                                         rst_n,
  input  logic                                         wr_en,
  input  logic [1:0]                                   wr_out,
  input  logic [1:0]                                   wr_word,
  input  logic [WORD_W-1:0]                            wdata,
  input  logic [N_WORDS-1:0][WORD_W-1:0]               pend,
  output logic [N_OUT-1:0][N_WORDS-1:0][WORD_W-1:0]    mask,
  output logic [N_OUT-1:0]                             irq
);
  logic [N_OUT-1:0][N_WORDS-1:0][WORD_W-1:0] mask_nxt;

  always_comb begin
    mask_nxt = mask;
    for (int o = 0; o < N_OUT; o++)
      for (int w = 0; w < N_WORDS; w++)
        if (wr_en && (wr_out == 2'(o)) && (wr_word == 2'(w)))
          mask_nxt[o][w] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask <= '0;
    else if (wr_en) mask <= mask_nxt;
  end

  for (genvar o = 0; o < N_OUT; o++) begin : g_line
    assign irq[o] = |(pend & mask[o]);
  end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned ID_W  = $clog2(WORD_W) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_set_valid,
  input  logic [ID_W-1:0]   ev_set_id,
  input  logic              ev_clr_valid,
  input  logic [ID_W-1:0]   ev_clr_id,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic [2:0]        irq
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  reg_sel_e   sel;
  logic [1:0] word;
  logic       word_ok, pend_wr, mask_wr;
  logic [1:0] mask_idx;

  assign sel      = reg_sel_e'(reg_addr[3:2]);
  assign word     = reg_addr[1:0];
  assign word_ok  = (word != 2'd3);
  assign pend_wr  = reg_wr && word_ok && (sel == SEL_PEND);
  assign mask_wr  = reg_wr && word_ok && (sel != SEL_PEND);
  assign mask_idx = reg_addr[3:2] - 2'd1;

  logic [N_WORDS-1:0][WORD_W-1:0]            set_hit, clr_hit, pend;
  logic [N_OUT-1:0][N_WORDS-1:0][WORD_W-1:0] mask;

  evt_decode #(.WORD_W(WORD_W)) u_set_dec (.vld(ev_set_valid), .id(ev_set_id), .hit(set_hit));
  evt_decode #(.WORD_W(WORD_W)) u_clr_dec (.vld(ev_clr_valid), .id(ev_clr_id), .hit(clr_hit));

  evt_pend_core #(.WORD_W(WORD_W)) u_pend (
    .clk(clk), .rst_n(rst_sync_n), .set_hit(set_hit), .clr_hit(clr_hit),
    .sw_wr(pend_wr), .sw_word(word), .sw_wdata(reg_wdata), .pend(pend)
  );

  evt_mask_bank #(.WORD_W(WORD_W)) u_mask (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(mask_wr), .wr_out(mask_idx),
    .wr_word(word), .wdata(reg_wdata), .pend(pend), .mask(mask), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (word == 2'(w)) begin
        if (sel == SEL_PEND) reg_rdata = pend[w];
        for (int o = 0; o < N_OUT; o++)
          if (mask_idx == 2'(o) && sel != SEL_PEND) reg_rdata = mask[o][w];
      end
    end
  end
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk
  import evt_irq_pkg::*;
#(
  parameter int unsigned WORD_W = 32,
  localparam int unsigned ID_W  = $clog2(WORD_W) + 2
) (
  input logic                                      clk,
  input logic                                      rst_n,
  input logic                                      ev_set_valid,
  input logic [ID_W-1:0]                           ev_set_id,
  input logic                                      ev_clr_valid,
  input logic                                      reg_wr,
  input logic [3:0]                                reg_addr,
  input logic [N_WORDS-1:0][WORD_W-1:0]            pend,
  input logic [N_OUT-1:0][N_WORDS-1:0][WORD_W-1:0] mask,
  input logic [N_OUT-1:0]                          irq
);
  logic [N_WORDS*WORD_W-1:0] flat;
  logic                      set_real;
  assign flat     = pend;
  assign set_real = ev_set_valid && (ev_set_id[ID_W-1:ID_W-2] != 2'd3);

  // R1 and R10: a set bit is present on the next edge whatever else happened
  a_r1_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    set_real |=> flat[$past(ev_set_id)]);

  for (genvar o = 0; o < N_OUT; o++) begin : g_irq
    a_r2_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      irq[o] == |(pend & mask[o]));
  end

  a_r3_casc_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set_valid && (ev_set_id[ID_W-1:ID_W-2] == 2'd1) |=> pend[0][WORD_W-2]);

  a_r3_casc_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set_valid && (ev_set_id[ID_W-1:ID_W-2] == 2'd2) |=> pend[0][WORD_W-1]);

  a_r4_summary_kept: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == 4'd0) && !ev_clr_valid |=>
      ((pend[0][WORD_W-1:WORD_W-2] & $past(pend[0][WORD_W-1:WORD_W-2]))
        == $past(pend[0][WORD_W-1:WORD_W-2])));

  a_r5_word1_readonly: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && (reg_addr == 4'd1) && !ev_clr_valid |=>
      ((pend[1] & $past(pend[1])) == $past(pend[1])));
endmodule

bind evt_irq_agg evt_irq_agg_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .ev_set_valid(ev_set_valid), .ev_set_id(ev_set_id),
  .ev_clr_valid(ev_clr_valid), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .pend(pend), .mask(mask), .irq(irq)
);

// File: tb/evt_irq_agg_test.sv
module evt_irq_agg_test;
  localparam logic [1:0] OP_SET = 2'd0, OP_CLR = 2'd1, OP_WR = 2'd2;

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  arg;
    logic [31:0] dat;
    logic [31:0] e0;
    logic [31:0] e1;
    logic [31:0] e2;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{OP_SET, 7'd3,   32'h0,        32'h0000_0008, 32'h0,         32'h0},         // R1
    '{OP_SET, 7'd37,  32'h0,        32'h4000_0008, 32'h0000_0020, 32'h0},         // R3
    '{OP_SET, 7'd70,  32'h0,        32'hC000_0008, 32'h0000_0020, 32'h0000_0040}, // R3
    '{OP_SET, 7'd127, 32'h0,        32'hC000_0008, 32'h0000_0020, 32'h0000_0040}, // R1 word 3
    '{OP_WR,  7'd0,   32'hFFFF_FFFF,32'hC000_0000, 32'h0000_0020, 32'h0000_0040}, // R4
    '{OP_WR,  7'd1,   32'hFFFF_FFFF,32'hC000_0000, 32'h0000_0020, 32'h0000_0040}, // R5
    '{OP_SET, 7'd66,  32'h0,        32'hC000_0000, 32'h0000_0020, 32'h0000_0044}, // R1
    '{OP_WR,  7'd2,   32'h0000_0040,32'hC000_0000, 32'h0000_0020, 32'h0000_0004}, // R6 partial
    '{OP_WR,  7'd2,   32'h0000_0004,32'h4000_0000, 32'h0000_0020, 32'h0},         // R6 drain
    '{OP_SET, 7'd40,  32'h0,        32'h4000_0000, 32'h0000_0120, 32'h0},         // R3
    '{OP_CLR, 7'd37,  32'h0,        32'h4000_0000, 32'h0000_0100, 32'h0},         // R7 not empty
    '{OP_CLR, 7'd40,  32'h0,        32'h0,         32'h0,         32'h0},         // R7 drain word 1
    '{OP_SET, 7'd95,  32'h0,        32'h8000_0000, 32'h0,         32'h8000_0000}, // R3
    '{OP_CLR, 7'd95,  32'h0,        32'h0,         32'h0,         32'h0},         // R7 drain word 2
    '{OP_SET, 7'd30,  32'h0,        32'h4000_0000, 32'h0,         32'h0},         // R1 direct
    '{OP_WR,  7'd0,   32'hFFFF_FFFF,32'h4000_0000, 32'h0,         32'h0},         // R4
    '{OP_CLR, 7'd30,  32'h0,        32'h0,         32'h0,         32'h0}          // R7
  };

  logic        clk, rst_n;
  logic        ev_set_valid, ev_clr_valid, reg_wr;
  logic [6:0]  ev_set_id, ev_clr_id;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [2:0]  irq;
  int          n_tests = 0, n_fail = 0;

  evt_irq_agg uut (
    .clk(clk), .rst_n(rst_n), .ev_set_valid(ev_set_valid), .ev_set_id(ev_set_id),
    .ev_clr_valid(ev_clr_valid), .ev_clr_id(ev_clr_id), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic check_rd(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic check_pend(input string req, input logic [31:0] e0, e1, e2);
    check_rd(req, 4'd0, e0);
    check_rd(req, 4'd1, e1);
    check_rd(req, 4'd2, e2);
  endtask

  task automatic fire(input logic sv, input logic [6:0] sid, input logic cv, input logic [6:0] cid,
                      input logic wv, input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    ev_set_valid = sv; ev_set_id = sid;
    ev_clr_valid = cv; ev_clr_id = cid;
    reg_wr = wv; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    ev_set_valid = 1'b0; ev_clr_valid = 1'b0; reg_wr = 1'b0;
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; ev_set_valid = 1'b0; ev_clr_valid = 1'b0; reg_wr = 1'b0;
    ev_set_id = '0; ev_clr_id = '0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R9: reset state
    check_pend("R9 pending after reset", 32'h0, 32'h0, 32'h0);
    check_rd("R9 mask A w0 after reset", 4'd4, 32'h0);
    check_rd("R9 mask C w2 after reset", 4'd14, 32'h0);
    check("R9 irq after reset", {29'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_SET:  fire(1'b1, VECS[i].arg, 1'b0, 7'd0, 1'b0, 4'd0, 32'h0);
        OP_CLR:  fire(1'b0, 7'd0, 1'b1, VECS[i].arg, 1'b0, 4'd0, 32'h0);
        default: fire(1'b0, 7'd0, 1'b0, 7'd0, 1'b1, VECS[i].arg[3:0], VECS[i].dat);
      endcase
      check_pend($sformatf("vector %0d (R1/R3-R7)", i), VECS[i].e0, VECS[i].e1, VECS[i].e2);
    end

    // R8: mask registers and address map
    fire(1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 4'd4,  32'h0000_0001);
    fire(1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 4'd9,  32'h0000_0010);
    fire(1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 4'd14, 32'h0000_0100);
    fire(1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 4'd7,  32'hFFFF_FFFF);
    check_rd("R8 mask A w0", 4'd4, 32'h0000_0001);
    check_rd("R8 mask B w1", 4'd9, 32'h0000_0010);
    check_rd("R8 mask C w2", 4'd14, 32'h0000_0100);
    check_rd("R8 word 3 reads zero", 4'd7, 32'h0);
    check("R2 idle irq", {29'b0, irq}, 32'h0);

    // R2: each line follows its own masks across words
    fire(1'b1, 7'd0, 1'b0, 7'd0, 1'b0, 4'd0, 32'h0);
    check("R2 line A", {29'b0, irq}, 32'h1);
    fire(1'b1, 7'd36, 1'b0, 7'd0, 1'b0, 4'd0, 32'h0);
    check("R2 line B", {29'b0, irq}, 32'h3);
    fire(1'b1, 7'd72, 1'b0, 7'd0, 1'b0, 4'd0, 32'h0);
    check("R2 line C", {29'b0, irq}, 32'h7);
    fire(1'b0, 7'd0, 1'b1, 7'd0, 1'b0, 4'd0, 32'h0);
    check("R2 A drops after clear", {29'b0, irq}, 32'h6);
    fire(1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 4'd4, 32'h4000_0000);
    check("R2 A on summary bit", {29'b0, irq}, 32'h7);
    fire(1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 4'd4, 32'h0);
    check("R2 A masked off", {29'b0, irq}, 32'h6);
    fire(1'b0, 7'd0, 1'b1, 7'd36, 1'b0, 4'd0, 32'h0);
    check("R7 B drops when word 1 drains", {29'b0, irq}, 32'h4);
    check_rd("R7 summary after word 1 drain", 4'd0, 32'h8000_0000);

    // R8: write to word index 3 of the pending group is ignored
    fire(1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 4'd3, 32'hFFFF_FFFF);
    check_pend("R8 pending word 3 write ignored", 32'h8000_0000, 32'h0, 32'h0000_0100);
    check_rd("R8 pending word 3 reads zero", 4'd3, 32'h0);
    fire(1'b0, 7'd0, 1'b0, 7'd0, 1'b1, 4'd2, 32'h0000_0100);
    check_pend("R6 drain clears summary", 32'h0, 32'h0, 32'h0);
    check("R2 all low after drains", {29'b0, irq}, 32'h0);

    // R10: same-cycle set and clear
    fire(1'b1, 7'd5, 1'b0, 7'd0, 1'b1, 4'd0, 32'h0000_0020);
    check_rd("R10 set beats software clear", 4'd0, 32'h0000_0020);
    fire(1'b1, 7'd5, 1'b1, 7'd5, 1'b0, 4'd0, 32'h0);
    check_rd("R10 set beats hardware clear", 4'd0, 32'h0000_0020);
    fire(1'b1, 7'd33, 1'b1, 7'd33, 1'b0, 4'd0, 32'h0);
    check_pend("R10 word 1 set beats clear", 32'h4000_0020, 32'h0000_0002, 32'h0);
    fire(1'b1, 7'd70, 1'b0, 7'd0, 1'b1, 4'd2, 32'h0000_0040);
    check_pend("R10 word 2 set beats write", 32'hC000_0020, 32'h0000_0002, 32'h0000_0040);

    // R9: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_pend("R9 pending after second reset", 32'h0, 32'h0, 32'h0);
    check_rd("R9 mask B w1 after second reset", 4'd9, 32'h0);
    check("R9 irq after second reset", {29'b0, irq}, 32'h0);

    summary();
    $finish;
  end
endmodule